// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block expands one column access into the column addresses of a whole burst, one per clock. A single-cycle start request captures a starting column, a burst length code and an ordering choice. From the next cycle on the block issues one column address per beat, flags each with a valid strobe and marks the final beat with a last flag. Only the three least significant column bits are reordered. All higher column bits are copied unchanged for the whole burst.

Two orderings are available. Sequential ordering counts upward and wraps inside a group of four beats. For a burst of eight, the first group of four stays in the starting half, and the second group switches to the other half. Interleaved ordering XORs the starting low bits with the beat index. A length code that is not one of the two supported values still runs a burst of eight, and an error flag is raised for that burst. While a burst is running, any new request is ignored, except on the last beat, where a request is accepted so that bursts can follow each other with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-low reset drives col_vld, burst_last and len_err low in the cycle after it is sampled, and this holds also when reset arrives in the middle of a burst.
- R2: A start accepted at a clock edge makes col_vld high from that edge for 4 consecutive cycles when len_code is 3'b010, and for 8 consecutive cycles when len_code is 3'b011. col_vld then drops, unless a new start was accepted on the last beat.
- R3: burst_last is high on the final beat of each burst only, and never while col_vld is low.
- R4: With burst_ilv=0 (sequential) and a burst of 4, beat i drives col_out[1:0] = (s[1:0]+i) mod 4, where s is col_in[2:0] at start, and holds col_out[2] = s[2].
- R5: With burst_ilv=0 and a burst of 8, beat i drives col_out[1:0] = (s[1:0]+i[1:0]) mod 4 and col_out[2] = s[2] XOR i[2]. Each group of four beats therefore wraps inside its own half.
- R6: With burst_ilv=1 (interleaved), beat i drives col_out[2:0] = s XOR i for a burst of 8. For a burst of 4 it drives col_out[1:0] = s[1:0] XOR i[1:0] and col_out[2] = s[2].
- R7: On every valid beat, col_out[COL_W-1:3] equals col_in[COL_W-1:3] as captured at the accepted start.
- R8: A len_code other than 3'b010 or 3'b011 runs a burst of 8 and sets len_err. len_err is recomputed at every accepted start, so a later supported code clears it, and it does not change during a burst.
- R9: A start while col_vld is high and burst_last is low is ignored. A start while burst_last is high is accepted, and the new burst's first beat follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Burst request, one cycle |
| col_in | input | COL_W | Starting column address |
| len_code | input | 3 | Burst length code: 3'b010 = 4, 3'b011 = 8 |
| burst_ilv | input | 1 | Ordering: 0 = sequential, 1 = interleaved |
| col_out | output | COL_W | Column address of the current beat |
| col_vld | output | 1 | Beat valid |
| burst_last | output | 1 | Final beat of the burst |
| len_err | output | 1 | Length code of the current burst was unsupported |

## Verification
The assertions assume two things about the inputs. First, col_in, len_code and burst_ilv matter only in the cycle where a start is accepted. Second, start may be held high for many cycles, including during a burst, and the design must reject that request until the last beat. The stimulus changes inputs only on falling clock edges and holds start for exactly one cycle in the table-driven bursts. The directed cases deliberately hold start high across the middle of a burst and raise it on the last beat, so that both the ignore path and the gapless restart are exercised.

// File: rtl/burst_seq_pkg.sv
// Shared constants and the beat ordering function for the burst column
// sequencer. Assumes bursts of at most eight beats (three reordered bits).
package burst_seq_pkg;

    localparam int LOW_W  = 3;
    localparam int BEAT_W = 3;

    localparam logic [2:0] BLC_FOUR  = 3'b010;
    localparam logic [2:0] BLC_EIGHT = 3'b011;

    // Low column bits for beat idx given start bits st, ordering and length.
    function automatic logic [LOW_W-1:0] beat_low(
        input logic [LOW_W-1:0]  st,
        input logic [BEAT_W-1:0] idx,
        input logic              ilv,
        input logic              is8
    );
        logic [1:0] lo;
        logic       hi;
        lo = ilv ? (st[1:0] ^ idx[1:0]) : (st[1:0] + idx[1:0]);
        hi = st[2] ^ (is8 & idx[2]);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/burst_len_decode.sv
// Decodes the burst length code. Assumes only codes for four and eight
// beats are legal; any other code selects eight beats and reports an error.
module burst_len_decode
    import burst_seq_pkg::*;
(
    input  logic [2:0] len_code,
    output logic       is8,
    output logic       len_bad
);

    // Map code to length select and error flag.
    always_comb begin
        unique case (len_code)
            BLC_FOUR:  begin is8 = 1'b0; len_bad = 1'b0; end
            BLC_EIGHT: begin is8 = 1'b1; len_bad = 1'b0; end
            default:   begin is8 = 1'b1; len_bad = 1'b1; end
        endcase
    end

endmodule

// File: rtl/burst_beat_ctrl.sv
// Beat counter and burst activity. A request is taken when idle or on the
// final beat; otherwise it is dropped. Assumes is8 is the latched length of
// the burst in progress.
module burst_beat_ctrl #(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is8,
    output logic              accept,
    output logic              busy,
    output logic [BEAT_W-1:0] beat,
    output logic              last
);

    localparam logic [BEAT_W-1:0] END4 = BEAT_W'(3);
    localparam logic [BEAT_W-1:0] END8 = BEAT_W'(7);

    // Final-beat detect and request acceptance window.
    always_comb begin
        last   = busy && (beat == (is8 ? END8 : END4));
        accept = start && (!busy || last);
    end

    // Advance the beat index and track burst activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            beat <= '0;
        end else if (last) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (busy) begin
            beat <= beat + BEAT_W'(1);
        end
    end

endmodule

// File: rtl/burst_col_order.sv
// Forms the column address of one beat from the captured start column.
// Upper bits pass through; the low three bits follow the selected order.
// Assumes COL_W >= 3.
module burst_col_order
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              ilv,
    input  logic              is8,
    output logic [COL_W-1:0]  col
);

    logic [LOW_W-1:0] low;

    // Reorder the low bits for this beat.
    always_comb low = beat_low(base[LOW_W-1:0], beat, ilv, is8);

    generate
        if (COL_W > LOW_W) begin : g_upper
            assign col = {base[COL_W-1:LOW_W], low};
        end else begin : g_low_only
            assign col = low[COL_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/burst_col_seq.sv
// Burst column address sequencer top. Captures the request context on an
// accepted start and emits one ordered column address per beat. Assumes
// inputs are only meaningful in the cycle a start is accepted.
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] col_in,
    input  logic [2:0]       len_code,
    input  logic             burst_ilv,
    output logic [COL_W-1:0] col_out,
    output logic             col_vld,
    output logic             burst_last,
    output logic             len_err
);

    logic              dec_is8;
    logic              dec_bad;
    logic              accept;
    logic              busy;
    logic              last;
    logic [BEAT_W-1:0] beat;
    logic [COL_W-1:0]  base_q;
    logic              ilv_q;
    logic              is8_q;
    logic              err_q;
    logic [COL_W-1:0]  ordered;

    burst_len_decode u_dec (
        .len_code (len_code),
        .is8      (dec_is8),
        .len_bad  (dec_bad)
    );

    burst_beat_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .is8    (is8_q),
        .accept (accept),
        .busy   (busy),
        .beat   (beat),
        .last   (last)
    );

    // Capture burst context when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ilv_q  <= 1'b0;
            is8_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (accept) begin
            base_q <= col_in;
            ilv_q  <= burst_ilv;
            is8_q  <= dec_is8;
            err_q  <= dec_bad;
        end
    end

    burst_col_order #(.COL_W(COL_W)) u_order (
        .base (base_q),
        .beat (beat),
        .ilv  (ilv_q),
        .is8  (is8_q),
        .col  (ordered)
    );

    // Drive outputs; address is zero outside a burst.
    always_comb begin
        col_out    = busy ? ordered : '0;
        col_vld    = busy;
        burst_last = last;
        len_err    = err_q;
    end

endmodule

// File: rtl/burst_col_seq_chk.sv
// Protocol checker for the burst column sequencer, attached by bind.
// Assumes COL_W > 3 so an upper column field exists.
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-4:0] col_in_up,
    input logic [COL_W-4:0] col_out_up,
    input logic             col_vld,
    input logic             burst_last,
    input logic             len_err
);

    logic [2:0]       beat_cnt;
    logic [COL_W-4:0] up_cap;
    logic             rst_seen;
    logic             acc;

    // Acceptance as seen at the ports.
    always_comb acc = start && (!col_vld || burst_last);

    // Count beats of the running burst, and capture the upper column field.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
        if (!rst_n) begin
            beat_cnt <= '0;
            up_cap   <= '0;
        end else begin
            beat_cnt <= (col_vld && !burst_last) ? beat_cnt + 3'd1 : 3'd0;
            if (acc) up_cap <= col_in_up;
        end
    end

    // R1: outputs idle after a sampled reset.
    always @(negedge clk) begin
        if (rst_seen) begin
            p_reset_idle_r1: assert (!col_vld && !burst_last && !len_err)
                else $error("p_reset_idle_r1");
        end
    end

    // R2: a burst ends after four or eight beats.
    p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last |-> (beat_cnt == 3'd3 || beat_cnt == 3'd7));

    // R2: an accepted request yields a valid beat next cycle.
    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> col_vld);

    // R3: last only inside a burst.
    p_last_vld_r3: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last |-> col_vld);

    // R3: burst stops after the last beat without a new request.
    p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_last && !start) |=> !col_vld);

    // R7: upper column field passes through.
    p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        col_vld |-> (col_out_up == up_cap));

    // R8: error flag steady within a burst.
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && !burst_last) |=> $stable(len_err));

    // R9: request in mid-burst is ignored.
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && !burst_last && start) |=> (col_vld && $stable(col_out_up)));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .col_in_up  (col_in[COL_W-1:3]),
    .col_out_up (col_out[COL_W-1:3]),
    .col_vld    (col_vld),
    .burst_last (burst_last),
    .len_err    (len_err)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;

    localparam int COL_W = 10;
    localparam int NV    = 8;

    // {ilv, len_code, col, beats, err, 8 expected low-bit values in octal}
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 3'b010, 10'h2B5, 4'd4, 1'b0, 24'o56740000},
        {1'b0, 3'b011, 10'h1C1, 4'd8, 1'b0, 24'o12305674},
        {1'b0, 3'b011, 10'h3F6, 4'd8, 1'b0, 24'o67452301},
        {1'b0, 3'b101, 10'h3A2, 4'd8, 1'b1, 24'o23016745},
        {1'b1, 3'b011, 10'h0AD, 4'd8, 1'b0, 24'o54761032},
        {1'b1, 3'b010, 10'h156, 4'd4, 1'b0, 24'o67450000},
        {1'b1, 3'b011, 10'h203, 4'd8, 1'b0, 24'o32107654},
        {1'b0, 3'b010, 10'h01B, 4'd4, 1'b0, 24'o30120000}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] col_in = '0;
    logic [2:0]       len_code = 3'b010;
    logic             burst_ilv = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_vld;
    logic             burst_last;
    logic             len_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .col_in     (col_in),
        .len_code   (len_code),
        .burst_ilv  (burst_ilv),
        .col_out    (col_out),
        .col_vld    (col_vld),
        .burst_last (burst_last),
        .len_err    (len_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] seq_at(input logic [23:0] seq, input int b);
        return seq[23-3*b -: 3];
    endfunction

    task automatic drive(input logic il, input logic [2:0] code,
                         input logic [COL_W-1:0] col);
        start     = 1'b1;
        burst_ilv = il;
        len_code  = code;
        col_in    = col;
    endtask

    // Called at a falling edge; runs one burst and checks every beat.
    task automatic run_burst(input logic [42:0] v);
        logic       il;
        logic [2:0] code;
        logic [9:0] col;
        int         n;
        logic       err;
        logic [23:0] seq;
        string      tag;
        il   = v[42];
        code = v[41:39];
        col  = v[38:29];
        n    = int'(v[28:25]);
        err  = v[24];
        seq  = v[23:0];
        tag  = il ? "R6" : ((n == 4) ? "R4" : "R5");
        drive(il, code, col);
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < n; b++) begin
            chk("R2", "col_vld in burst", 32'(col_vld), 32'd1);
            chk(tag, "low column bits", 32'(col_out[2:0]), 32'(seq_at(seq, b)));
            chk("R7", "upper column bits", 32'(col_out[COL_W-1:3]), 32'(col[COL_W-1:3]));
            chk("R3", "burst_last", 32'(burst_last), 32'(b == n - 1));
            chk("R8", "len_err", 32'(len_err), 32'(err));
            @(negedge clk);
        end
        chk("R2", "col_vld after burst", 32'(col_vld), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "col_vld in reset", 32'(col_vld), 32'd0);
        chk("R1", "burst_last in reset", 32'(burst_last), 32'd0);
        chk("R1", "len_err in reset", 32'(len_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "col_vld after reset", 32'(col_vld), 32'd0);

        // Table of bursts
        for (int k = 0; k < NV; k++) run_burst(VEC[k]);

        // R8: all-ones code is unsupported: eight sequential beats from 0
        run_burst({1'b0, 3'b111, 10'h000, 4'd8, 1'b1, 24'o01234567});
        // R8: supported code clears the error flag
        run_burst(VEC[1]);

        // R9: start held during mid-burst beats is ignored
        drive(1'b0, 3'b011, 10'h1C1);
        @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            chk("R9", "low bits under held start", 32'(col_out[2:0]),
                32'(seq_at(24'o12305674, b)));
            chk("R9", "burst_last under held start", 32'(burst_last), 32'(b == 7));
            if (b >= 1 && b <= 5) drive(1'b1, 3'b010, 10'h000);
            else start = 1'b0;
            @(negedge clk);
        end
        chk("R9", "col_vld after ignored start", 32'(col_vld), 32'd0);

        // R9: start on last beat begins the next burst without a gap
        drive(1'b0, 3'b010, 10'h01B);
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < 3; b++) @(negedge clk);
        chk("R9", "on last beat", 32'(burst_last), 32'd1);
        drive(1'b0, 3'b010, 10'h2B5);
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < 4; b++) begin
            chk("R9", "back-to-back col_vld", 32'(col_vld), 32'd1);
            chk("R9", "back-to-back column", 32'(col_out),
                32'({7'h56, seq_at(24'o56740000, b)}));
            @(negedge clk);
        end
        chk("R9", "col_vld after back-to-back", 32'(col_vld), 32'd0);

        // R1: reset in mid-burst clears everything
        drive(1'b0, 3'b111, 10'h0F0);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R8", "len_err set before reset", 32'(len_err), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "col_vld mid-burst reset", 32'(col_vld), 32'd0);
        chk("R1", "len_err mid-burst reset", 32'(len_err), 32'd0);
        chk("R1", "burst_last mid-burst reset", 32'(burst_last), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule